// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 256K x 8 words. The host presents one request at a time: a read or a write of a single byte at an 18-bit address. The controller registers the address and write data, then drives the RAM's two chip selects (one active-low, one active-high, always switched together), its output enable and its write enable. Each phase lasts long enough to meet the slow speed grade of the RAM: 70 ns access, 60 ns select and address to end of write, a 50 ns write pulse and 30 ns data setup. When the access is done it pulses a one-cycle acknowledge. A read returns the byte sampled from the RAM's data bus.

All timing values are given in nanoseconds as parameters together with the clock period. Each one becomes a cycle count: the ceiling of the time divided by the period, and never less than one cycle. The shared data bus is split into an output value, an output enable and an input value, so a pad ring or a tri-state buffer can join them. The controller drives the bus only while a write pulse is in progress. After a read it waits out the RAM's output release time before it accepts another request.

Top module: `sramc_top`

## Requirements
- R1: While reset is high and afterwards until a request arrives, the RAM is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `ack`=0 and `req_ready`=1.
- R2: A request is taken only in the clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the accepting edge until the access and its turnaround are over. A request held while `req_ready` is 0 is ignored: it produces no acknowledge and no change to memory.
- R3: A read selects the RAM with `mem_oe_n`=0 and `mem_we_n`=1. It samples `mem_dq_i` and raises `ack` with that byte on `rd_data` N_RD cycles after the accepting edge. N_RD is the larger of ceil(70 ns / period) and ceil(70 ns / period) minus one, so 18 cycles at a 4 ns clock.
- R4: A write keeps `mem_oe_n`=1 throughout. It lowers `mem_we_n` N_AS cycles after acceptance (1 at 4 ns) and holds it low for N_WP cycles. N_WP is the largest of the 50 ns pulse, the 30 ns data setup plus one cycle, and the 60 ns select and address windows minus N_AS (14 cycles at 4 ns). Each write pulse therefore lasts at least 50 ns. The address and select are held for at least 60 ns before the pulse ends.
- R5: `mem_dq_oe` is 1 only from one cycle after `mem_we_n` falls until one cycle after it rises. The written byte is stable on `mem_dq_o` for at least 30 ns before `mem_we_n` rises.
- R6: A write raises `ack` N_AS+N_WP+N_WH cycles after the accepting edge, where N_WH is the larger of one cycle and ceil(70 ns / period)-N_AS-N_WP. That is 18 cycles at 4 ns. `ack` is always a single-cycle pulse.
- R7: After a read, `mem_oe_n` rises one cycle after `ack`. No new request is taken for ceil(25 ns / period) cycles after that. The controller never drives the bus while the RAM is driving it or may still be releasing it.
- R8: `mem_addr` stays constant while the RAM is selected. A read returns the byte most recently written to that address.
- R9: Between accesses the RAM is deselected, with both selects inactive at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller idle, request will be taken |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte, valid with ack |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_dq_i | input | 8 | Data bus as seen from the RAM |

## Verification
Read and write acknowledges are both due 18 cycles after the accepting edge at the default 4 ns clock. The bench works out each latency from nanosecond values and stores it with the queued item. It samples the acknowledge half a cycle after the edge that raises it, so the count is exact. A bench model of the RAM counts, at every falling clock edge, how long the address, output enable, selects and driven data have been stable. It returns a junk byte until 70 ns of address age and 35 ns of output-enable age have passed, so a capture taken even one cycle early reads back wrong. The same model scores each write pulse against the nanosecond limits and flags any drive of the bus during the RAM's release window.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_CAP,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } sramc_state_e;

    typedef struct packed {
        logic sel;
        logic rd_en;
        logic wr_en;
        logic drive;
    } sramc_strobe_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
    import sramc_pkg::*;
#(
    parameter int N_RD  = 18,
    parameter int N_AS  = 1,
    parameter int N_WP  = 14,
    parameter int N_WH  = 3,
    parameter int N_OHZ = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic ack,
    output logic sel,
    output logic rd_en,
    output logic wr_en,
    output logic drive
);
    localparam int NMAX = max2(max2(N_RD, N_AS), max2(max2(N_WP, N_WH), N_OHZ));
    localparam int CW   = $clog2(NMAX + 1);

    sramc_state_e  state;
    sramc_strobe_t strb;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;

    sramc_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state == ST_RD_ACC) && t_zero;

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: begin
                t_load = accept;
                t_val  = req_write ? CW'(N_AS - 1) : CW'(N_RD - 1);
            end
            ST_RD_CAP: begin
                t_load = 1'b1;
                t_val  = CW'(N_OHZ - 1);
            end
            ST_WR_SETUP: begin
                t_load = t_zero;
                t_val  = CW'(N_WP - 1);
            end
            ST_WR_PULSE: begin
                t_load = t_zero;
                t_val  = CW'(N_WH - 1);
            end
            default: begin
                t_load = 1'b0;
                t_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            strb  <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    strb.sel <= 1'b1;
                    if (req_write) begin
                        state <= ST_WR_SETUP;
                    end else begin
                        strb.rd_en <= 1'b1;
                        state      <= ST_RD_ACC;
                    end
                end
                ST_RD_ACC: if (t_zero) begin
                    ack   <= 1'b1;
                    state <= ST_RD_CAP;
                end
                ST_RD_CAP: begin
                    strb.sel   <= 1'b0;
                    strb.rd_en <= 1'b0;
                    state      <= ST_TURN;
                end
                ST_TURN: if (t_zero) state <= ST_IDLE;
                ST_WR_SETUP: if (t_zero) begin
                    strb.wr_en <= 1'b1;
                    state      <= ST_WR_PULSE;
                end
                ST_WR_PULSE: begin
                    strb.drive <= 1'b1;
                    if (t_zero) begin
                        strb.wr_en <= 1'b0;
                        state      <= ST_WR_HOLD;
                    end
                end
                ST_WR_HOLD: begin
                    strb.drive <= 1'b0;
                    if (t_zero) begin
                        strb.sel <= 1'b0;
                        ack      <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sel   = strb.sel;
    assign rd_en = strb.rd_en;
    assign wr_en = strb.wr_en;
    assign drive = strb.drive;

    // R4
    no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    // R5
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        drive |-> (wr_en || $past(wr_en)));

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R9
    strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en || drive) |-> sel);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
endmodule

// File: rtl/sramc_dp.sv
module sramc_dp #(
    parameter int AW = 18,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= in_addr;
                wdata_q <= in_wdata;
            end
            if (capture) rdata_q <= dq_in;
        end
    end

    // R3
    capture_not_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !(accept && capture));
endmodule

// File: rtl/sramc_top.sv
module sramc_top
    import sramc_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 8,
    parameter int CLK_NS   = 4,
    parameter int T_AA_NS  = 70,
    parameter int T_RC_NS  = 70,
    parameter int T_OHZ_NS = 25,
    parameter int T_WC_NS  = 70,
    parameter int T_CW_NS  = 60,
    parameter int T_AW_NS  = 60,
    parameter int T_WP_NS  = 50,
    parameter int T_AS_NS  = 0,
    parameter int T_WR_NS  = 0,
    parameter int T_DW_NS  = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          ack,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int N_AA  = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int N_RD  = max2(N_AA, ns_to_cyc(T_RC_NS, CLK_NS) - 1);
    localparam int N_AS  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int N_DW  = ns_to_cyc(T_DW_NS, CLK_NS);
    localparam int N_WP  = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), N_DW + 1),
                                max2(ns_to_cyc(T_CW_NS, CLK_NS) - N_AS,
                                     ns_to_cyc(T_AW_NS, CLK_NS) - N_AS));
    localparam int N_WH  = max2(ns_to_cyc(T_WR_NS, CLK_NS),
                                ns_to_cyc(T_WC_NS, CLK_NS) - N_AS - N_WP);
    localparam int N_OHZ = ns_to_cyc(T_OHZ_NS, CLK_NS);

    logic accept, capture, sel, rd_en, wr_en, drive;

    sramc_fsm #(
        .N_RD(N_RD), .N_AS(N_AS), .N_WP(N_WP), .N_WH(N_WH), .N_OHZ(N_OHZ)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .accept(accept), .capture(capture), .ack(ack),
        .sel(sel), .rd_en(rd_en), .wr_en(wr_en), .drive(drive)
    );

    sramc_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .in_addr(req_addr), .in_wdata(req_wdata), .dq_in(mem_dq_i),
        .addr_q(mem_addr), .wdata_q(mem_dq_o), .rdata_q(rd_data)
    );

    assign mem_cs_n  = ~sel;
    assign mem_cs    = sel;
    assign mem_oe_n  = ~rd_en;
    assign mem_we_n  = ~wr_en;
    assign mem_dq_oe = drive;

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> $stable(mem_addr));

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_we_n && !mem_dq_oe));
endmodule

// File: tb/sramc_top_bench.sv
module sramc_top_bench;
    localparam int CLK = 4;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD  = mx(cyc_of(70), cyc_of(70) - 1);
    localparam int E_AS  = cyc_of(0);
    localparam int E_WP  = mx(mx(cyc_of(50), cyc_of(30) + 1), cyc_of(60) - E_AS);
    localparam int E_WH  = mx(1, cyc_of(70) - E_AS - E_WP);
    localparam int E_WR  = E_AS + E_WP + E_WH;
    localparam int E_OHZ = cyc_of(25);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, ack;
    logic [7:0] rd_data;
    logic [17:0] mem_addr;
    logic mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0] mem_dq_o, mem_dq_i;

    always #(CLK/2) clk = ~clk;

    sramc_top u_sramc_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .ack(ack), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- RAM model ----------------
    logic [7:0] ram [logic [17:0]];
    logic [17:0] last_addr = '0;
    int addr_age = 0, oe_age = 0, sel_age = 0, wp_age = 0, d_age = 0, hold = 0;
    logic [7:0] last_d = '0;
    bit wr_act_q = 0, rd_drv_q = 0, ram_drv = 0;
    logic [7:0] ram_val = 8'hEE;
    logic [17:0] wr_addr = '0;

    wire selected = !mem_cs_n && mem_cs;

    always @(negedge clk) if (!rst) begin
        bit rd_drv, wr_act;
        addr_age = (mem_addr != last_addr) ? 0 : addr_age + 1;
        last_addr = mem_addr;
        oe_age  = (selected && !mem_oe_n) ? oe_age + 1 : -1;
        sel_age = selected ? sel_age + 1 : 0;
        d_age   = (mem_dq_oe && mem_dq_o == last_d) ? d_age + 1 : (mem_dq_oe ? 1 : 0);
        last_d  = mem_dq_o;
        rd_drv  = selected && !mem_oe_n && mem_we_n;
        wr_act  = selected && !mem_we_n;
        if (rd_drv_q && !rd_drv) hold = E_OHZ;
        else if (hold > 0) hold--;
        rd_drv_q = rd_drv;
        if (rd_drv && (addr_age*CLK + CLK >= 70) && (oe_age*CLK + CLK >= 35) && ram.exists(mem_addr))
            ram_val = ram[mem_addr];
        else
            ram_val = 8'hEE;
        ram_drv = rd_drv || hold > 0;
        if (mem_dq_oe && ram_drv) check(0, "R7 bus contention", 1, 0);
        if (mem_dq_oe && mem_we_n && !wr_act_q) check(0, "R5 drive outside write", 1, 0);
        if (!mem_oe_n && !mem_we_n) check(0, "R4 oe during write", 0, 1);
        if (wr_act) begin
            if (!wr_act_q) begin wp_age = 0; wr_addr = mem_addr; end
            wp_age++;
            if (mem_addr != wr_addr) check(0, "R8 address moved in write", mem_addr, wr_addr);
        end
        if (wr_act_q && !wr_act) begin
            check(wp_age*CLK >= 50, "R4 write pulse width ns", wp_age*CLK, 50);
            check(wp_age == E_WP, "R4 write pulse cycles", wp_age, E_WP);
            check((sel_age-1)*CLK >= 60, "R4 select to end ns", (sel_age-1)*CLK, 60);
            check(d_age >= 0 && (d_age-1)*CLK >= 30, "R5 data setup ns", (d_age-1)*CLK, 30);
        end
        if (wr_act) ram[mem_addr] = mem_dq_o;
        wr_act_q = wr_act;
    end

    assign mem_dq_i = ram_drv ? ram_val : (mem_dq_oe ? mem_dq_o : 8'h5A);

    // ---------------- scoreboard ----------------
    typedef struct { bit wr; logic [17:0] a; logic [7:0] d; int c0; } item_t;
    item_t q[$];
    logic [7:0] refm [logic [17:0]];
    bit ack_q = 0;

    always @(negedge clk) if (!rst) begin
        if (ack && ack_q) check(0, "R6 ack longer than one cycle", 1, 0);
        if (ack && !ack_q) begin
            if (q.size() == 0) check(0, "R2 acknowledge with no request", 1, 0);
            else begin
                item_t it;
                it = q.pop_front();
                if (it.wr) check(cyc - it.c0 == E_WR, "R6 write ack latency", cyc - it.c0, E_WR);
                else begin
                    check(cyc - it.c0 == E_RD, "R3 read ack latency", cyc - it.c0, E_RD);
                    check(rd_data == it.d, "R8 read data", rd_data, it.d);
                end
            end
        end
        ack_q = ack;
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        it.wr = wr; it.a = a; it.c0 = cyc;
        if (wr) begin refm[a] = d; it.d = d; end
        else it.d = refm.exists(a) ? refm[a] : 8'hEE;
        q.push_back(it);
    endtask

    task automatic drain();
        int n = 0;
        while ((q.size() != 0 || !req_ready) && n < 1000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(mem_cs_n == 1 && mem_cs == 0, "R1 deselect in reset", {mem_cs_n, mem_cs}, 2);
        check(mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset", {mem_oe_n, mem_we_n, mem_dq_oe}, 6);
        rst = 0;
        @(negedge clk);
        check(req_ready && !ack, "R1 ready after reset", {req_ready, ack}, 2);
        check(mem_cs_n == 1 && mem_cs == 0, "R9 idle deselect", {mem_cs_n, mem_cs}, 2);

        // writes, boundary addresses and data patterns
        issue(1, 18'h00000, 8'h00);
        // R4: during the write output enable stays high
        repeat (3) @(negedge clk);
        check(mem_oe_n == 1 && mem_we_n == 0, "R4 strobes mid write", {mem_oe_n, mem_we_n}, 2);
        issue(1, 18'h3FFFF, 8'hFF);
        issue(1, 18'h12345, 8'hA5);
        issue(1, 18'h2AAAA, 8'h5A);
        drain();
        check(mem_cs_n == 1 && mem_cs == 0, "R9 deselect after writes", {mem_cs_n, mem_cs}, 2);

        // reads back
        issue(0, 18'h00000, 8'h00);
        repeat (3) @(negedge clk);
        check(!mem_oe_n && mem_we_n && !mem_dq_oe, "R3 read strobes", {mem_oe_n, mem_we_n, mem_dq_oe}, 2);
        issue(0, 18'h3FFFF, 8'h00);
        issue(0, 18'h12345, 8'h00);
        issue(0, 18'h2AAAA, 8'h00);

        // R7 turnaround: read directly followed by write and read
        issue(1, 18'h00001, 8'h3C);
        issue(0, 18'h00001, 8'h00);
        issue(1, 18'h12345, 8'hC3);
        issue(0, 18'h12345, 8'h00);
        drain();

        // R7 ready stays low after oe rises
        issue(0, 18'h3FFFF, 8'h00);
        begin
            int k = 0;
            while (!ack) begin @(negedge clk); k++; end
            @(negedge clk);
            check(mem_oe_n == 1, "R7 oe rises after ack", mem_oe_n, 1);
            repeat (E_OHZ - 1) @(negedge clk);
            check(!req_ready, "R7 no accept in release window", req_ready, 0);
        end
        drain();

        // R2 ignored request while busy
        issue(1, 18'h00100, 8'h11);
        issue(1, 18'h00200, 8'h22);
        check(!req_ready, "R2 busy after accept", req_ready, 0);
        req_valid = 1; req_write = 1; req_addr = 18'h00100; req_wdata = 8'h77;
        repeat (3) @(negedge clk);
        check(!req_ready, "R2 still busy while request held", req_ready, 0);
        req_valid = 0;
        drain();
        issue(0, 18'h00100, 8'h00);
        issue(0, 18'h00200, 8'h00);
        drain();
        check(q.size() == 0, "R2 queue empty at end", q.size(), 0);
        finish_run();
    end
endmodule